// File: doc/BRIEF.md
# Shared-Counter Dual-Slope Conversion Sequencer

This block runs the digital side of a bank of parallel dual-slope converters from a single free-running sample counter. The counter walks through one full sample period and splits it into three phases that every channel shares: de-integration in the lower half, then auto-zero, then a fixed-length integration window in the top quarter. Because every converter de-integrates from the same starting instant, the same counter doubles as the conversion counter: when a channel's comparator trips, the low bits of the count at that moment are that channel's result.

Each comparator line is resynchronized before use. A channel records only the first trip it sees in a de-integration window, and a channel that never trips records the full-scale code. Captured results sit in a first register per channel and are moved together into an output bank once per period, at the start of integration, so downstream logic sees a complete, coherent set of codes that holds for one whole period.

Top module: `dsconv_seq`

## Requirements
- R1: With the count c (0 to 255, starting at 0 after reset and advancing by one per clock, wrapping 255 to 0), `az_o` is high exactly for c in 128..191, `int_o` exactly for c in 192..255, and both are low for c in 0..127.
- R2: While reset is low and in the cycle after its release, the count is 0, every `dint_o` bit is high, `az_o` and `int_o` are low, and every output code is 0.
- R3: Each trip line passes through two flip-flops: a trip line raised during the cycle with count t (t from 0 to 125, or 254 and 255 counted as -2 and -1 of the next period) yields the captured code t+2.
- R4: Only the first trip in a de-integration window is captured; later falls and rises of the same line in that window leave the code unchanged.
- R5: A channel that has not tripped by the end of count 127 captures the saturated code 127.
- R6: `dint_o[k]` is high from count 0 up to and including the count at which channel k captures, and low for the rest of the period.
- R7: The output codes change only when the count moves from 191 to 192, where all channels take their newly captured values together; at every other count they hold.
- R8: A trip line high during auto-zero or integration does not capture; only its synchronized level reaching count 0 or later counts.
- R9: Channel k's code occupies bits [7k+6 : 7k] of `code_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, counter advances every rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| trip_i | input | 16 | Comparator trip line per channel, asynchronous |
| az_o | output | 1 | Auto-zero phase control, shared by all channels |
| int_o | output | 1 | Integrate phase control, shared by all channels |
| dint_o | output | 16 | Per-channel de-integration control, drops once the channel has captured |
| code_o | output | 112 | Synchronized 7-bit code per channel, channel k at bits [7k+6:7k] |

## Verification
The bench builds the block with its default values of 16 channels and an 8-bit counter, which keeps a full sample period at 256 cycles, so eight complete periods and every count within them are checked cycle by cycle. Trip times are chosen per channel and period so that the earliest codes 0 and 1 (raised in the previous period's integrate window), mid-range codes, code 127 and never-tripping channels all appear, and in alternate periods each tripped line is dropped and raised again to probe first-trip capture.

// File: rtl/dsconv_pkg.sv
// Shared types for the dual-slope conversion sequencer.
package dsconv_pkg;

    // Phase of the shared sample period, decoded from the top counter bits.
    typedef enum logic [1:0] {
        PH_DEINT = 2'd0,
        PH_AZ    = 2'd1,
        PH_INT   = 2'd2
    } phase_e;

endpackage

// File: rtl/dsconv_timebase.sv
// Free-running sample counter and phase decoder.
// Assumes CNT_W >= 3. The lower half of the period is de-integration,
// the third quarter auto-zero and the top quarter integration.
module dsconv_timebase
    import dsconv_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o,
    output phase_e           phase_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // Advance the shared counter, wrapping naturally at full scale.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Decode the phase from the two most significant bits.
    always_comb begin
        unique case (cnt_q[CNT_W-1 -: 2])
            2'b10:   phase_o = PH_AZ;
            2'b11:   phase_o = PH_INT;
            default: phase_o = PH_DEINT;
        endcase
    end

    assign cnt_o = cnt_q;

    assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) |=> (cnt_q == '0));

    assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/dsconv_chan.sv
// One converter channel: two-flop trip synchronizer, first-trip capture
// of the low counter bits during de-integration, saturation at the end
// of the window. Assumes the trip line is asynchronous to clk.
module dsconv_chan
    import dsconv_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int CODE_W = CNT_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trip_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  phase_e            phase_i,
    output logic [CODE_W-1:0] code_o,
    output logic              dint_o
);

    localparam logic [CNT_W-1:0] LAST_DEINT = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic [CNT_W-1:0] CNT_MAX    = '1;

    logic              sync1_q, sync2_q;
    logic              done_q;
    logic [CODE_W-1:0] code_q;
    logic              take;

    // Capture on the first synchronized trip, or force full scale at the window end.
    assign take = (phase_i == PH_DEINT) && !done_q && (sync2_q || (cnt_i == LAST_DEINT));

    // Bring the comparator line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= trip_i;
            sync2_q <= sync1_q;
        end
    end

    // Hold the first-stage code and the captured flag for this period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            code_q <= '0;
        end else if (cnt_i == CNT_MAX) begin
            done_q <= 1'b0;
        end else if (take) begin
            done_q <= 1'b1;
            code_q <= cnt_i[CODE_W-1:0];
        end
    end

    assign dint_o = (phase_i == PH_DEINT) && !done_q;
    assign code_o = code_q;

    assert_capture_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> ($past(cnt_i) <= LAST_DEINT));

    assert_first_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(done_q) |-> $stable(code_q));

    assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i == LAST_DEINT + 1'b1) |-> done_q);

endmodule

// File: rtl/dsconv_bank.sv
// Second-stage output bank: copies every first-stage code at once when
// the counter steps into the integrate phase, and holds otherwise.
module dsconv_bank #(
    parameter int NUM_CH = 16,
    parameter int CNT_W  = 8,
    parameter int CODE_W = CNT_W - 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CNT_W-1:0]         cnt_i,
    input  logic [NUM_CH*CODE_W-1:0] stage1_i,
    output logic [NUM_CH*CODE_W-1:0] code_o
);

    localparam logic [CNT_W-1:0] XFER_AT = {2'b11, {(CNT_W-2){1'b0}}};

    logic [NUM_CH*CODE_W-1:0] bank_q;

    // Transfer on the edge that brings the count to the integrate start.
    always_ff @(posedge clk) begin
        if (!rst_n)                        bank_q <= '0;
        else if (cnt_i == XFER_AT - 1'b1)  bank_q <= stage1_i;
    end

    assign code_o = bank_q;

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i != XFER_AT) |-> $stable(bank_q));

endmodule

// File: rtl/dsconv_seq.sv
// Top of the shared-counter dual-slope sequencer: one timebase, one
// capture channel per converter, one synchronized output bank.
// Assumes every channel's analog integrator follows az_o, int_o and dint_o.
module dsconv_seq
    import dsconv_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CNT_W  = 8,
    localparam int CODE_W = CNT_W - 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        trip_i,
    output logic                     az_o,
    output logic                     int_o,
    output logic [NUM_CH-1:0]        dint_o,
    output logic [NUM_CH*CODE_W-1:0] code_o
);

    logic [CNT_W-1:0]         cnt;
    phase_e                   phase;
    logic [NUM_CH*CODE_W-1:0] stage1;

    dsconv_timebase #(.CNT_W(CNT_W)) timebase_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_o   (cnt),
        .phase_o (phase)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
        dsconv_chan #(.CNT_W(CNT_W), .CODE_W(CODE_W)) chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .trip_i  (trip_i[k]),
            .cnt_i   (cnt),
            .phase_i (phase),
            .code_o  (stage1[k*CODE_W +: CODE_W]),
            .dint_o  (dint_o[k])
        );
    end

    dsconv_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .CODE_W(CODE_W)) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_i    (cnt),
        .stage1_i (stage1),
        .code_o   (code_o)
    );

    assign az_o  = (phase == PH_AZ);
    assign int_o = (phase == PH_INT);

    assert_phase_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(az_o && int_o) && !((az_o || int_o) && (dint_o != '0)));

endmodule

// File: tb/dsconv_seq_tb_top.sv
module dsconv_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int CW = 7;
    localparam int PERIODS = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [N-1:0]      trip;
    logic              az_o, int_o;
    logic [N-1:0]      dint_o;
    logic [N*CW-1:0]   code_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int tgt_cur[N];
    int tgt_next[N];
    int exp_out[N];
    int p;
    int m;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsconv_seq dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .trip_i (trip),
        .az_o   (az_o),
        .int_o  (int_o),
        .dint_o (dint_o),
        .code_o (code_o)
    );

    // Target capture code per period and channel; 128 means never trip.
    function automatic int pick(int per, int ch);
        if (per == 0) return 2 + ch * 7;
        if (per == 1 && ch == 0) return 0;
        if (per == 1 && ch == 1) return 1;
        if (per == 1 && ch == 2) return 127;
        if (per == 1 && ch == 3) return 128;
        return (ch * 23 + per * 41 + ch * ch) % 129;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp, input int ch);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s ch %0d count %0d: actual %0d expected %0d", req, ch, m, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Check all outputs against the expected state at count m.
    task automatic check_cycle();
        bit exp_az, exp_int, exp_d;
        check(az_o == ((m >= 128) && (m < 192)), "R1", az_o, (m >= 128) && (m < 192), -1);
        check(int_o == (m >= 192), "R1", int_o, m >= 192, -1);
        for (int ch = 0; ch < N; ch++) begin
            exp_d = (m < 128) && ((tgt_cur[ch] > 127) || (m <= tgt_cur[ch]));
            check(dint_o[ch] == exp_d, "R6", dint_o[ch], exp_d, ch);
            if (m == 192) begin
                if (tgt_cur[ch] > 127)
                    check(code_o[ch*CW +: CW] == exp_out[ch], "R5", code_o[ch*CW +: CW], exp_out[ch], ch);
                else if (tgt_cur[ch] < 2)
                    check(code_o[ch*CW +: CW] == exp_out[ch], "R8", code_o[ch*CW +: CW], exp_out[ch], ch);
                else if (p % 2 == 1 && tgt_cur[ch] <= 120)
                    check(code_o[ch*CW +: CW] == exp_out[ch], "R4", code_o[ch*CW +: CW], exp_out[ch], ch);
                else
                    check(code_o[ch*CW +: CW] == exp_out[ch], "R3", code_o[ch*CW +: CW], exp_out[ch], ch);
            end else begin
                // R9 field position, R7 hold between transfers
                check(code_o[ch*CW +: CW] == exp_out[ch], "R7", code_o[ch*CW +: CW], exp_out[ch], ch);
            end
        end
    endtask

    // Drive the trip lines for count m.
    task automatic drive_cycle();
        for (int ch = 0; ch < N; ch++) begin
            int t;
            t = tgt_cur[ch];
            if (t >= 2 && t <= 127 && m == t - 2) trip[ch] = 1'b1;
            if (p % 2 == 1 && t <= 120) begin
                if (m == t)     trip[ch] = 1'b0;
                if (m == t + 3) trip[ch] = 1'b1;
            end
            if (m == 254 && tgt_next[ch] == 0) trip[ch] = 1'b1;
            if (m == 255 && tgt_next[ch] == 1) trip[ch] = 1'b1;
        end
        // Trips high during auto-zero are ignored (R8); clear at its start.
        if (m == 128) trip = '0;
        // A line raised in auto-zero must not capture: raise channel 15 briefly.
        if (m == 140 && tgt_next[N-1] != 0 && tgt_next[N-1] != 1) trip[N-1] = 1'b1;
        if (m == 150) trip[N-1] = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        trip  = '0;
        p = 0;
        m = 0;
        for (int ch = 0; ch < N; ch++) begin
            tgt_next[ch] = pick(0, ch);
            tgt_cur[ch]  = tgt_next[ch];
            exp_out[ch]  = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2: reset state while reset is held
        check(dint_o == '1, "R2", dint_o, 16'hFFFF, -1);
        check(code_o == '0, "R2", 0, 0, -1);
        check(!az_o && !int_o, "R2", az_o | int_o, 0, -1);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < PERIODS * 256; cyc++) begin
            if (m == 0 && cyc != 0) begin
                p++;
                for (int ch = 0; ch < N; ch++) tgt_cur[ch] = tgt_next[ch];
            end
            if (m == 192)
                for (int ch = 0; ch < N; ch++) exp_out[ch] = (tgt_cur[ch] > 127) ? 127 : tgt_cur[ch];
            if (m == 200)
                for (int ch = 0; ch < N; ch++) tgt_next[ch] = pick(p + 1, ch);
            check_cycle();
            drive_cycle();
            @(posedge clk);
            @(negedge clk);
            m = (m + 1) % 256;
        end
        finish_run();
    end

endmodule